// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block sits beside the execute stage of a processor core. It decides whether a cache-block zeroing or cache-block management instruction (clean, flush, invalidate) may proceed, and if not, which trap it raises. The caller presents the following on a single-cycle request strobe:

- the operation;
- the current privilege level and the virtualization flag;
- the enable fields of three environment-configuration levels (machine, hypervisor, supervisor);
- the virtual address;
- the read and write permission results that an external translation and protection lookup produced for the block.

One cycle later the checker returns three things: the address aligned down to the cache block, an allowed strobe, and a cause code. The memory operation itself and the address translation happen elsewhere.

The configuration levels are checked in a fixed priority. Machine level comes first, then the virtualized case, then supervisor level. Only a request that passes all three reaches the permission rule. That rule depends on the operation. Zeroing needs store permission. Management operations need either read or write permission.

Top module: `cbo_perm_check`

## Requirements
- R1: A request sampled with `req_valid` high at a rising edge produces `rsp_valid` high for exactly the following cycle. Without a request, `rsp_valid` is low.
- R2: `rsp_addr` equals the request address with its low log2(BLOCK_BYTES) bits cleared. The upper bits are unchanged.
- R3: Privilege is encoded U=0, S=1, M=3. Below M, a clear enable in `cfg_m` gives cause 1 (illegal instruction). Cause codes are: 0 none, 1 illegal instruction, 2 virtual instruction, 3 store fault.
- R4: With `req_virt` high and the machine check passed, cause 2 results in either of two cases: privilege is S or U and the `cfg_h` enable is clear, or privilege is U and the `cfg_s` enable is clear.
- R5: With `req_virt` low and the machine check passed, privilege U with a clear `cfg_s` enable gives cause 1.
- R6: When several checks fail, the machine-level check decides before the virtualized check, and the virtualized check decides before the supervisor-level check.
- R7: The operation codes are 0 zero, 1 clean, 2 flush, 3 invalidate. Each configuration port holds a zero enable in bit 0 and a clean/flush enable in bit 1. Bits 3:2 form the invalidate field, which counts as enabled when it is nonzero. Each operation tests only its own field.
- R8: A zeroing request that passes the configuration checks gives cause 3 when `perm_wr` is low and cause 0 when it is high. `perm_rd` is ignored.
- R9: A management request that passes the configuration checks gives cause 0 when `perm_rd` or `perm_wr` is high, and cause 3 when both are low.
- R10: At privilege M, all three configuration ports are ignored, and only the permission rule applies.
- R11: `rsp_allowed` is high exactly when `rsp_valid` is high and the cause is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_op | input | 2 | Operation code (0 zero, 1 clean, 2 flush, 3 invalidate) |
| req_priv | input | 2 | Privilege level (0 U, 1 S, 3 M) |
| req_virt | input | 1 | Virtualization active |
| cfg_m | input | 4 | Machine-level enable fields |
| cfg_h | input | 4 | Hypervisor-level enable fields |
| cfg_s | input | 4 | Supervisor-level enable fields |
| req_vaddr | input | ADDR_W | Virtual address of the access |
| perm_rd | input | 1 | Lookup result: block readable |
| perm_wr | input | 1 | Lookup result: block writable |
| rsp_valid | output | 1 | Result valid |
| rsp_allowed | output | 1 | Operation may proceed |
| rsp_cause | output | 2 | Cause code (0 none, 1 illegal, 2 virtual, 3 store fault) |
| rsp_addr | output | ADDR_W | Block-aligned address |

## Verification
The assertions assume that the privilege input never carries the reserved value 2 while a request is presented. They also assume that the permission and configuration inputs are meaningful only in the request cycle. One property checks the first assumption directly. The bench drives privilege only from the set U, S, M. It applies every input at the falling edge together with the strobe and removes the strobe at the next falling edge, so the assumptions hold throughout the stimulus.

// File: rtl/cbo_pkg.sv
package cbo_pkg;

   typedef enum logic [1:0] {
      OP_ZERO  = 2'd0,
      OP_CLEAN = 2'd1,
      OP_FLUSH = 2'd2,
      OP_INVAL = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      CAUSE_NONE    = 2'd0,
      CAUSE_ILLEGAL = 2'd1,
      CAUSE_VIRTUAL = 2'd2,
      CAUSE_STORE   = 2'd3
   } cause_e;

   localparam logic [1:0] PRIV_U = 2'd0;
   localparam logic [1:0] PRIV_S = 2'd1;
   localparam logic [1:0] PRIV_M = 2'd3;

   localparam int CFG_W       = 4;
   localparam int CFG_ZERO_B  = 0;
   localparam int CFG_CF_B    = 1;
   localparam int CFG_INV_LO  = 2;
   localparam int CFG_INV_HI  = 3;

   // Pick the enable that governs a given operation out of one level's fields.
   function automatic logic cfg_enable(input op_e op, input logic [CFG_W-1:0] cfg);
      logic en;
      unique case (op)
         OP_ZERO:            en = cfg[CFG_ZERO_B];
         OP_CLEAN, OP_FLUSH: en = cfg[CFG_CF_B];
         default:            en = |cfg[CFG_INV_HI:CFG_INV_LO];
      endcase
      return en;
   endfunction

endpackage

// File: rtl/cbo_cfg_gate.sv
module cbo_cfg_gate
   import cbo_pkg::*;
(
   input  op_e               op,
   input  logic [1:0]        priv,
   input  logic              virt,
   input  logic [CFG_W-1:0]  cfg_m,
   input  logic [CFG_W-1:0]  cfg_h,
   input  logic [CFG_W-1:0]  cfg_s,
   output cause_e            gate_cause
);

   logic en_m, en_h, en_s;
   logic below_m, at_or_below_s, below_s;
   logic fail_m, fail_v, fail_s;

   assign en_m = cfg_enable(op, cfg_m);
   assign en_h = cfg_enable(op, cfg_h);
   assign en_s = cfg_enable(op, cfg_s);

   assign below_m       = (priv != PRIV_M);
   assign at_or_below_s = (priv <= PRIV_S);
   assign below_s       = (priv < PRIV_S);

   assign fail_m = below_m && !en_m;
   assign fail_v = virt && ((at_or_below_s && !en_h) || (below_s && !en_s));
   assign fail_s = below_s && !en_s;

   // Fixed priority: machine, then virtualized, then supervisor level.
   always_comb begin
      if (fail_m)      gate_cause = CAUSE_ILLEGAL;
      else if (fail_v) gate_cause = CAUSE_VIRTUAL;
      else if (fail_s) gate_cause = CAUSE_ILLEGAL;
      else             gate_cause = CAUSE_NONE;
   end

endmodule

// File: rtl/cbo_access_rule.sv
module cbo_access_rule
   import cbo_pkg::*;
(
   input  op_e   op,
   input  logic  perm_rd,
   input  logic  perm_wr,
   output logic  access_ok
);

   logic is_zero;

   assign is_zero = (op == OP_ZERO);

   // Zeroing writes the block; management accepts a readable or writable block.
   always_comb begin
      if (is_zero) access_ok = perm_wr;
      else         access_ok = perm_rd || perm_wr;
   end

endmodule

// File: rtl/cbo_block_align.sv
module cbo_block_align #(
   parameter int ADDR_W      = 32,
   parameter int BLOCK_BYTES = 64
) (
   input  logic [ADDR_W-1:0] vaddr,
   output logic [ADDR_W-1:0] aligned
);

   localparam int OFS_W = $clog2(BLOCK_BYTES);

   generate
      if (OFS_W == 0) begin : g_byte_block
         assign aligned = vaddr;
      end else begin : g_mask_block
         localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << OFS_W) - ADDR_W'(1);
         assign aligned = vaddr & ~LOW_MASK;
      end
   endgenerate

endmodule

// File: rtl/cbo_perm_check.sv
module cbo_perm_check
   import cbo_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int BLOCK_BYTES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [1:0]        req_priv,
   input  logic              req_virt,
   input  logic [3:0]        cfg_m,
   input  logic [3:0]        cfg_h,
   input  logic [3:0]        cfg_s,
   input  logic [ADDR_W-1:0] req_vaddr,
   input  logic              perm_rd,
   input  logic              perm_wr,
   output logic              rsp_valid,
   output logic              rsp_allowed,
   output logic [1:0]        rsp_cause,
   output logic [ADDR_W-1:0] rsp_addr
);

   localparam int OFS_W = $clog2(BLOCK_BYTES);

   generate
      if (BLOCK_BYTES < 1 || (BLOCK_BYTES & (BLOCK_BYTES - 1)) != 0) begin : g_bad_block
         $error("BLOCK_BYTES must be a power of two");
      end
      if (OFS_W >= ADDR_W) begin : g_bad_width
         $error("ADDR_W must exceed the block offset width");
      end
   endgenerate

   op_e                 op;
   cause_e              gate_cause;
   logic                access_ok;
   cause_e              next_cause;
   logic [ADDR_W-1:0]   aligned;
   cause_e              cause_q;
   logic                valid_q;
   logic [ADDR_W-1:0]   addr_q;

   assign op = op_e'(req_op);

   cbo_cfg_gate i_gate (
      .op         (op),
      .priv       (req_priv),
      .virt       (req_virt),
      .cfg_m      (cfg_m),
      .cfg_h      (cfg_h),
      .cfg_s      (cfg_s),
      .gate_cause (gate_cause)
   );

   cbo_access_rule i_rule (
      .op        (op),
      .perm_rd   (perm_rd),
      .perm_wr   (perm_wr),
      .access_ok (access_ok)
   );

   cbo_block_align #(
      .ADDR_W      (ADDR_W),
      .BLOCK_BYTES (BLOCK_BYTES)
   ) i_align (
      .vaddr   (req_vaddr),
      .aligned (aligned)
   );

   // Configuration traps outrank the permission rule.
   always_comb begin
      if (gate_cause != CAUSE_NONE) next_cause = gate_cause;
      else if (!access_ok)          next_cause = CAUSE_STORE;
      else                          next_cause = CAUSE_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         cause_q <= CAUSE_NONE;
         addr_q  <= '0;
      end else begin
         valid_q <= req_valid;
         if (req_valid) begin
            cause_q <= next_cause;
            addr_q  <= aligned;
         end
      end
   end

   assign rsp_valid   = valid_q;
   assign rsp_cause   = cause_q;
   assign rsp_addr    = addr_q;
   assign rsp_allowed = valid_q && (cause_q == CAUSE_NONE);

endmodule

// File: rtl/cbo_perm_check_sva.sv
module cbo_perm_check_sva #(
   parameter int ADDR_W      = 32,
   parameter int BLOCK_BYTES = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_op,
   input logic [1:0]        req_priv,
   input logic              req_virt,
   input logic [ADDR_W-1:0] req_vaddr,
   input logic              perm_rd,
   input logic              perm_wr,
   input logic              rsp_valid,
   input logic              rsp_allowed,
   input logic [1:0]        rsp_cause,
   input logic [ADDR_W-1:0] rsp_addr
);

   localparam int OFS_W = $clog2(BLOCK_BYTES);

   // Input assumption: reserved privilege value never requested.
   priv_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> req_priv != 2'd2);

   // R1
   rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   // R1
   rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   // R2
   addr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (rsp_addr >> OFS_W) == ($past(req_vaddr) >> OFS_W));

   // R2
   addr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_addr & ((ADDR_W'(1) << OFS_W) - ADDR_W'(1))) == '0);

   // R4
   virt_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_virt) |=> rsp_cause != 2'd2);

   // R10
   mach_no_cfg_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_priv == 2'd3) |=> (rsp_cause == 2'd0 || rsp_cause == 2'd3));

   // R8
   zero_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_priv == 2'd3 && req_op == 2'd0 && !perm_wr) |=> rsp_cause == 2'd3);

   // R9
   mgmt_readable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_priv == 2'd3 && req_op != 2'd0 && perm_rd) |=> rsp_allowed);

   // R11
   allowed_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_allowed == (rsp_valid && rsp_cause == 2'd0));

endmodule

bind cbo_perm_check cbo_perm_check_sva #(
   .ADDR_W      (ADDR_W),
   .BLOCK_BYTES (BLOCK_BYTES)
) i_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_op      (req_op),
   .req_priv    (req_priv),
   .req_virt    (req_virt),
   .req_vaddr   (req_vaddr),
   .perm_rd     (perm_rd),
   .perm_wr     (perm_wr),
   .rsp_valid   (rsp_valid),
   .rsp_allowed (rsp_allowed),
   .rsp_cause   (rsp_cause),
   .rsp_addr    (rsp_addr)
);

// File: tb/test_cbo_perm_check.sv
module test_cbo_perm_check;

   localparam int CLK_PERIOD  = 10;
   localparam int ADDR_W      = 32;
   localparam int BLOCK_BYTES = 64;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [1:0]        req_op = '0;
   logic [1:0]        req_priv = '0;
   logic              req_virt = 1'b0;
   logic [3:0]        cfg_m = '0, cfg_h = '0, cfg_s = '0;
   logic [ADDR_W-1:0] req_vaddr = '0;
   logic              perm_rd = 1'b0, perm_wr = 1'b0;
   logic              rsp_valid, rsp_allowed;
   logic [1:0]        rsp_cause;
   logic [ADDR_W-1:0] rsp_addr;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cbo_perm_check #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) i_cbo_perm_check (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_priv(req_priv), .req_virt(req_virt), .cfg_m(cfg_m), .cfg_h(cfg_h),
      .cfg_s(cfg_s), .req_vaddr(req_vaddr), .perm_rd(perm_rd), .perm_wr(perm_wr),
      .rsp_valid(rsp_valid), .rsp_allowed(rsp_allowed), .rsp_cause(rsp_cause),
      .rsp_addr(rsp_addr)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Enable of one level for an op, from the field layout in R7.
   function automatic logic en_of(input logic [1:0] op, input logic [3:0] c);
      if (op == 2'd0) return c[0];
      if (op == 2'd3) return c[3] | c[2];
      return c[1];
   endfunction

   // Expected cause from R3..R10.
   function automatic logic [1:0] model(input logic [1:0] op, input logic [1:0] pv,
                                         input logic vt, input logic [3:0] m,
                                         input logic [3:0] h, input logic [3:0] s,
                                         input logic rd, input logic wr);
      if (pv != 2'd3 && !en_of(op, m)) return 2'd1;
      if (vt && ((pv <= 2'd1 && !en_of(op, h)) || (pv == 2'd0 && !en_of(op, s)))) return 2'd2;
      if (pv == 2'd0 && !en_of(op, s)) return 2'd1;
      if (op == 2'd0) return wr ? 2'd0 : 2'd3;
      return (rd || wr) ? 2'd0 : 2'd3;
   endfunction

   // Drive one request at a falling edge; results are read at the next falling edge.
   task automatic issue(input logic [1:0] op, input logic [1:0] pv, input logic vt,
                        input logic [3:0] m, input logic [3:0] h, input logic [3:0] s,
                        input logic rd, input logic wr, input logic [ADDR_W-1:0] va);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_priv = pv; req_virt = vt;
      cfg_m = m; cfg_h = h; cfg_s = s; perm_rd = rd; perm_wr = wr; req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Fields for an op with enable e; every other field gets the opposite value.
   function automatic logic [3:0] cfg_for(input logic [1:0] op, input logic e);
      if (op == 2'd0) return {{2{~e}}, ~e, e};
      if (op == 2'd3) return {e, 1'b0, ~e, ~e};
      return {{2{~e}}, e, ~e};
   endfunction

   task automatic t_reset();
      check("R1 reset valid", rsp_valid, 1'b0);
      check("R11 reset allowed", rsp_allowed, 1'b0);
      check("R1 reset cause", rsp_cause, 2'd0);
   endtask

   task automatic t_timing();
      issue(2'd1, 2'd3, 1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 32'h100);
      check("R1 valid after request", rsp_valid, 1'b1);
      check("R11 allowed in M", rsp_allowed, 1'b1);
      @(negedge clk);
      check("R1 single cycle pulse", rsp_valid, 1'b0);
      check("R11 allowed drops", rsp_allowed, 1'b0);
   endtask

   task automatic t_align();
      issue(2'd1, 2'd3, 1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b1, 32'hDEAD_BEEF);
      check("R2 mid-block address", rsp_addr, 32'hDEAD_BEC0);
      issue(2'd0, 2'd3, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b1, 32'hFFFF_FFFF);
      check("R2 top address", rsp_addr, 32'hFFFF_FFC0);
      issue(2'd0, 2'd3, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b1, 32'h0000_0040);
      check("R2 already aligned", rsp_addr, 32'h0000_0040);
   endtask

   task automatic t_priority();
      // Machine clear plus hypervisor clear while virtualized: machine wins.
      issue(2'd1, 2'd1, 1'b1, 4'h0, 4'h0, 4'hF, 1'b1, 1'b1, 32'h0);
      check("R6 machine beats virtual", rsp_cause, 2'd1);
      // Virtualized U with supervisor clear: virtual beats supervisor-level illegal.
      issue(2'd1, 2'd0, 1'b1, 4'hF, 4'hF, 4'h0, 1'b1, 1'b1, 32'h0);
      check("R4 virtual beats supervisor", rsp_cause, 2'd2);
      // Non-virtualized U with supervisor clear.
      issue(2'd1, 2'd0, 1'b0, 4'hF, 4'h0, 4'h0, 1'b1, 1'b1, 32'h0);
      check("R5 supervisor illegal", rsp_cause, 2'd1);
      // Config trap beats a missing permission.
      issue(2'd0, 2'd1, 1'b0, 4'h0, 4'hF, 4'hF, 1'b0, 1'b0, 32'h0);
      check("R3 trap before permission", rsp_cause, 2'd1);
   endtask

   task automatic t_inval_field();
      for (int v = 1; v < 4; v++) begin
         issue(2'd3, 2'd0, 1'b0, {v[1:0], 2'b00}, 4'h0, {v[1:0], 2'b00}, 1'b1, 1'b0, 32'h0);
         check("R7 invalidate nonzero field", rsp_cause, 2'd0);
      end
      issue(2'd3, 2'd1, 1'b0, 4'b0011, 4'hF, 4'hF, 1'b1, 1'b1, 32'h0);
      check("R7 invalidate field zero", rsp_cause, 2'd1);
   endtask

   task automatic t_perm();
      issue(2'd0, 2'd3, 1'b0, 4'h0, 4'h0, 4'h0, 1'b1, 1'b0, 32'h0);
      check("R8 zero read only faults", rsp_cause, 2'd3);
      issue(2'd0, 2'd3, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b1, 32'h0);
      check("R8 zero write ok", rsp_cause, 2'd0);
      issue(2'd2, 2'd3, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b1, 32'h0);
      check("R9 flush write only ok", rsp_cause, 2'd0);
      issue(2'd3, 2'd3, 1'b0, 4'h0, 4'h0, 4'h0, 1'b0, 1'b0, 32'h0);
      check("R9 invalidate no access", rsp_cause, 2'd3);
      check("R11 not allowed on fault", rsp_allowed, 1'b0);
   endtask

   task automatic t_sweep();
      logic [1:0] privs [3] = '{2'd0, 2'd1, 2'd3};
      for (int op = 0; op < 4; op++)
         for (int pi = 0; pi < 3; pi++)
            for (int vt = 0; vt < 2; vt++)
               for (int c = 0; c < 8; c++)
                  for (int p = 0; p < 4; p++) begin
                     logic [3:0] m, h, s;
                     logic [1:0] exp;
                     m = cfg_for(op[1:0], c[2]);
                     h = cfg_for(op[1:0], c[1]);
                     s = cfg_for(op[1:0], c[0]);
                     exp = model(op[1:0], privs[pi], vt[0], m, h, s, p[1], p[0]);
                     issue(op[1:0], privs[pi], vt[0], m, h, s, p[1], p[0], 32'h1234_5678);
                     check("R3 R4 R5 R10 sweep cause", rsp_cause, exp);
                     check("R11 sweep allowed", rsp_allowed, exp == 2'd0);
                  end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_timing();
      t_align();
      t_priority();
      t_inval_field();
      t_perm();
      t_sweep();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule